// File: doc/BRIEF.md
# Burst Serial Port with Eight-Byte Buffer

This block is a synchronous serial port that moves 8-bit words through a small addressed buffer. Before a transfer, the host fills the buffer entries through a plain write port. It then issues a single start command that carries a byte count. The port shifts the first 1 to 8 entries out in order, with no further help from the host. Each byte clocked in from the far side overwrites the buffer entry whose byte has just been sent. When the last bit of the last byte has been sampled, busy drops and a one-cycle done pulse is raised. The host then reads the received bytes back through the same addressed port.

The serial clock comes from one of two sources:
- **Internal clock:** the port generates its own clock, which idles high and has a fixed period in system clock cycles.
- **External clock:** the port follows a clock driven by the far side. That clock, the data input and the select input are brought into the system domain through two-flop synchronizers.

An optional select-gated mode uses an active-low select input. Activity is allowed only while select is low, and the clock and data output enables drop at once when select is high. If select rises in the middle of a byte, that byte is thrown away. It is sent again from its first bit once select returns low.

Top module: `sfx_burst_port`

## Requirements
- R1: After reset, busy_o=0, done_o=0, sck_o=1, sck_oe_o=1, sdo_oe_o=1 and sdo_o=0.
- R2: A host write (host_we_i=1) stores host_wdata_i into the entry at host_addr_i, and host_rdata_o shows the entry at host_addr_i without delay. A write is ignored while busy_o=1, and also in a cycle where start_i=1.
- R3: When busy_o=0, start_i=1 latches the length code len_i (value 0 means 8 bytes, value n from 1 to 7 means n bytes) and sends entries 0 up to length-1 in index order. busy_o is high from the next cycle until the last sample. A start_i while busy_o=1 is ignored.
- R4: Bits are sent MSB first. sdo_o shows bit 7 of a byte before that byte's first rising clock edge, and it changes only when the clock falls. sdi_i is captured on each rising edge.
- R5: With the internal clock, sck_o idles at 1 whenever busy_o=0. Each bit uses SCK_HALF system cycles low followed by SCK_HALF cycles high, so consecutive rising edges are 2*SCK_HALF cycles apart (16 by default).
- R6: The byte received during byte k, MSB first, is written into entry k when its eighth bit is sampled. Entries at or above the length are left unchanged.
- R7: With the external clock (ext_clk_i=1 at start), sck_oe_o=0, and the port acts on the edges of sck_i after they pass a two-flop synchronizer.
- R8: In select-gated mode (cs_mode_i=1 at start), sdo_oe_o (and sck_oe_o when the internal clock is used) follow cs_ni low at once and are 0 while cs_ni=1. No clock edges are produced or accepted while select is high.
- R9: If select rises in the middle of a byte in select-gated mode, that byte is dropped and busy_o stays 1. When select returns low, the same entry is sent again starting from bit 7, and the total byte count does not change.
- R10: done_o is high for exactly one cycle per transfer, in the first cycle where busy_o is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host buffer write strobe |
| host_addr_i | input | 3 | Host buffer entry index |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Buffer entry at host_addr_i |
| start_i | input | 1 | Start a burst |
| len_i | input | 3 | Burst length code (0 means 8) |
| ext_clk_i | input | 1 | 1 selects the external serial clock |
| cs_mode_i | input | 1 | 1 selects select-gated transfer |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | Output enable for sck_o |
| sck_i | input | 1 | External serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| sdi_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Select, active low |

## Verification
A host write and a start command can fall in the same cycle. The write then loses, so the burst has to send the old contents of entry 0. The bench forces this collision by raising both strobes on the same edge with different data. It judges the result from the first byte seen on sdo_o and from a later readback of entry 0, which must hold the received byte.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  parameter int unsigned DATA_W_DEF   = 8;
  parameter int unsigned DEPTH_DEF    = 8;
  parameter int unsigned SCK_HALF_DEF = 8;

  typedef enum logic {CLK_INT = 1'b0, CLK_EXT = 1'b1} clk_src_e;
endpackage

// File: rtl/sfx_sync.sv
module sfx_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sfx_clkgen.sv
module sfx_clkgen #(
  parameter int unsigned HALF = 8,
  localparam int unsigned CW = $clog2(HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          toggle;

  assign toggle = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (toggle) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = toggle && !sck_q;
  assign fall_o = toggle && sck_q;
endmodule

// File: rtl/sfx_buffer.sv
module sfx_buffer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              eng_we_i,
  input  logic [AW-1:0]     eng_widx_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  input  logic [AW-1:0]     eng_ridx_i,
  output logic [DATA_W-1:0] eng_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (eng_we_i && eng_widx_i == AW'(g)) begin
        mem_q[g] <= eng_wdata_i;
      end else if (host_we_i && host_addr_i == AW'(g)) begin
        mem_q[g] <= host_wdata_i;
      end
    end
  end

  assign host_rdata_o = mem_q[host_addr_i];
  assign eng_rdata_o  = mem_q[eng_ridx_i];

  p_single_writer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_we_i && eng_we_i));
endmodule

// File: rtl/sfx_burst_port.sv
module sfx_burst_port
  import sfx_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned DEPTH    = DEPTH_DEF,
  parameter int unsigned SCK_HALF = SCK_HALF_DEF,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              start_i,
  input  logic [AW-1:0]     len_i,
  input  logic              ext_clk_i,
  input  logic              cs_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sck_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i,
  input  logic              cs_ni
);
  clk_src_e          cfg_src_q;
  logic              cfg_cs_q;
  logic              busy_q, done_q, load_pend_q, sck_prev_q;
  logic [AW-1:0]     byte_idx_q, last_idx_q;
  logic [BW-1:0]     bit_cnt_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;

  logic              sck_s, sdi_s, cs_n_s, cs_low_s;
  logic              is_ext, gate_ok, run, abort, start_go;
  logic              m_sck, m_rise, m_fall, s_rise, s_fall, rise_ev, fall_ev;
  logic              sample_bit, byte_end, last_byte, host_we_g;
  logic [DATA_W-1:0] rx_next, eng_rdata;
  logic [AW-1:0]     eng_ridx;

  sfx_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, sdi_i, cs_ni}),
    .q_o   ({sck_s, sdi_s, cs_n_s})
  );

  assign is_ext   = (cfg_src_q == CLK_EXT);
  assign cs_low_s = !cs_n_s;
  assign gate_ok  = !cfg_cs_q || cs_low_s;
  assign run      = busy_q && gate_ok;
  assign abort    = busy_q && cfg_cs_q && !cs_low_s;
  assign start_go = start_i && !busy_q;

  sfx_clkgen #(.HALF(SCK_HALF)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run && !is_ext),
    .sck_o (m_sck),
    .rise_o(m_rise),
    .fall_o(m_fall)
  );

  assign s_rise  = sck_s && !sck_prev_q;
  assign s_fall  = !sck_s && sck_prev_q;
  assign rise_ev = run && (is_ext ? s_rise : m_rise);
  assign fall_ev = run && (is_ext ? s_fall : m_fall);

  assign sample_bit = is_ext ? sdi_s : sdi_i;
  assign rx_next    = {rx_sh_q[DATA_W-2:0], sample_bit};
  assign byte_end   = rise_ev && (bit_cnt_q == BW'(DATA_W - 1));
  assign last_byte  = (byte_idx_q == last_idx_q);
  assign host_we_g  = host_we_i && !busy_q && !start_i;
  assign eng_ridx   = start_go ? '0 : byte_idx_q;

  sfx_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (host_we_g),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .eng_we_i    (byte_end),
    .eng_widx_i  (byte_idx_q),
    .eng_wdata_i (rx_next),
    .eng_ridx_i  (eng_ridx),
    .eng_rdata_o (eng_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_src_q   <= CLK_INT;
      cfg_cs_q    <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      load_pend_q <= 1'b0;
      sck_prev_q  <= 1'b1;
      byte_idx_q  <= '0;
      last_idx_q  <= '0;
      bit_cnt_q   <= '0;
      tx_sh_q     <= '0;
      rx_sh_q     <= '0;
    end else begin
      sck_prev_q <= sck_s;
      done_q     <= 1'b0;
      if (start_go) begin
        cfg_src_q   <= ext_clk_i ? CLK_EXT : CLK_INT;
        cfg_cs_q    <= cs_mode_i;
        busy_q      <= 1'b1;
        last_idx_q  <= (len_i == '0) ? AW'(DEPTH - 1) : len_i - AW'(1);
        byte_idx_q  <= '0;
        bit_cnt_q   <= '0;
        load_pend_q <= 1'b0;
        tx_sh_q     <= eng_rdata;
        rx_sh_q     <= '0;
      end else if (abort) begin
        // partial byte dropped; same entry restarts from its MSB
        bit_cnt_q   <= '0;
        load_pend_q <= 1'b0;
        tx_sh_q     <= eng_rdata;
        rx_sh_q     <= '0;
      end else if (rise_ev) begin
        rx_sh_q <= rx_next;
        if (byte_end) begin
          bit_cnt_q <= '0;
          if (last_byte) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            byte_idx_q  <= byte_idx_q + AW'(1);
            load_pend_q <= 1'b1;
          end
        end else begin
          bit_cnt_q <= bit_cnt_q + BW'(1);
        end
      end else if (fall_ev) begin
        if (bit_cnt_q != '0) begin
          tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        end else if (load_pend_q) begin
          tx_sh_q     <= eng_rdata;
          load_pend_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign sck_o    = m_sck;
  assign sdo_o    = tx_sh_q[DATA_W-1];
  assign sdo_oe_o = !cfg_cs_q || !cs_ni;
  assign sck_oe_o = !is_ext && (!cfg_cs_q || !cs_ni);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_sdo_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_ext && !cfg_cs_q && busy_q && $past(busy_q) && !$stable(sdo_o)) |-> $fell(sck_o));

  p_idle_sck_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o);

  p_pause_sck_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cfg_cs_q && !cs_low_s) |=> sck_o);

  p_wr_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_end |-> (byte_idx_q <= last_idx_q));
endmodule

// File: tb/tb_sfx_burst_port.sv
module tb_sfx_burst_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_we_i = 1'b0;
  logic [2:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       start_i = 1'b0;
  logic [2:0] len_i = '0;
  logic       ext_clk_i = 1'b0;
  logic       cs_mode_i = 1'b0;
  logic       busy_o, done_o, sck_o, sck_oe_o, sdo_o, sdo_oe_o;
  logic       sck_i = 1'b1;
  logic       sdi_i = 1'b0;
  logic       cs_ni = 1'b1;

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  int rise_cnt = 0;
  logic [7:0] bmem [8];
  logic [7:0] mrx [8];
  logic [7:0] exp_q [$];
  logic       mon_m = 1'b0;
  logic [6:0] mbit = '0;
  logic [7:0] mbits = '0;
  int         mcnt = 0;
  time        rise_t = 0;

  always #10 clk = ~clk;

  sfx_burst_port dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .start_i(start_i), .len_i(len_i),
    .ext_clk_i(ext_clk_i), .cs_mode_i(cs_mode_i), .busy_o(busy_o), .done_o(done_o),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sck_i(sck_i), .sdo_o(sdo_o),
    .sdo_oe_o(sdo_oe_o), .sdi_i(sdi_i), .cs_ni(cs_ni)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  // done pulse monitor (R10, R3)
  initial forever begin
    @(negedge clk);
    if (done_o) begin
      done_cnt++;
      chk(!busy_o, "R3", 32'(busy_o), 32'd0);
    end
  end

  // internal-clock scoreboard monitor: sdo sampled at each rising sck_o
  initial forever begin
    @(posedge sck_o);
    #1;
    if (mon_m) begin
      if (rise_t != 0) chk(($time - rise_t) == 64'd320, "R5", 32'($time - rise_t), 32'd320);
      rise_t = $time;
      rise_cnt++;
      mbits = {mbits[6:0], sdo_o};
      mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        if (exp_q.size() == 0) chk(1'b0, "R3", 32'(mbits), 32'hFFFF);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mbits == e, "R4", 32'(mbits), 32'(e));
        end
      end
    end
  end

  // far-side model: new sdi bit after each falling sck_o
  initial forever begin
    @(negedge sck_o);
    #1;
    if (mon_m && !mbit[6]) begin
      sdi_i = mrx[mbit[5:3]][3'd7 - mbit[2:0]];
      mbit = mbit + 7'd1;
    end
  end

  task automatic write_buf(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we_i = 1'b1; host_addr_i = a; host_wdata_i = d;
    @(negedge clk);
    host_we_i = 1'b0;
    bmem[a] = d;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    host_addr_i = a;
    #1;
    chk(host_rdata_o == e, req, 32'(host_rdata_o), 32'(e));
  endtask

  task automatic pulse_start(input logic [2:0] l, input logic ext, input logic csm);
    @(negedge clk);
    len_i = l; ext_clk_i = ext; cs_mode_i = csm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic arm_master(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(bmem[3'(k)]);
      mrx[3'(k)] = seed ^ 8'(k * 29);
    end
    mbit = '0; mcnt = 0; rise_cnt = 0; rise_t = 0; done_cnt = 0;
    mon_m = 1'b1;
  endtask

  task automatic finish_master(input int n, input string req);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    mon_m = 1'b0;
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
    chk(rise_cnt == 8 * n, req, 32'(rise_cnt), 32'(8 * n));
    chk(done_cnt == 1, "R10", 32'(done_cnt), 32'd1);
    for (int k = 0; k < n; k++) bmem[3'(k)] = mrx[3'(k)];
    for (int k = 0; k < 8; k++) rd_chk(3'(k), bmem[3'(k)], "R6");
  endtask

  // external clock: drive nbits of rxb, capture sdo just before each rise
  task automatic slave_bits(input logic [7:0] rxb, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk);
      sck_i = 1'b0; sdi_i = rxb[3'(i)];
      repeat (6) @(negedge clk);
      got[3'(i)] = sdo_o;
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic slave_byte(input logic [7:0] rxb, input string req);
    logic [7:0] got, e;
    slave_bits(rxb, 8, got);
    e = exp_q.pop_front();
    chk(got == e, req, 32'(got), 32'(e));
  endtask

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", {30'd0, busy_o, done_o}, 32'd0);
    chk(sck_o && sck_oe_o && sdo_oe_o && !sdo_o, "R1",
        {28'd0, sck_o, sck_oe_o, sdo_oe_o, sdo_o}, 32'hE);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 host fill and readback
    for (int k = 0; k < 8; k++) write_buf(3'(k), 8'h81 + 8'(k * 37));
    for (int k = 0; k < 8; k++) rd_chk(3'(k), bmem[3'(k)], "R2");

    // R3 R4 R5 three-byte burst, internal clock; write and restart ignored while busy
    arm_master(3, 8'h5A);
    pulse_start(3'd3, 1'b0, 1'b0);
    chk(busy_o == 1'b1, "R3", 32'(busy_o), 32'd1);
    repeat (40) @(negedge clk);
    @(negedge clk);
    host_we_i = 1'b1; host_addr_i = 3'd6; host_wdata_i = 8'h00;
    @(negedge clk);
    host_we_i = 1'b0;
    pulse_start(3'd1, 1'b0, 1'b0);
    finish_master(3, "R3");

    // R3 length code 0 means eight bytes
    arm_master(8, 8'hC7);
    pulse_start(3'd0, 1'b0, 1'b0);
    finish_master(8, "R3");

    // R2 collision: write in start cycle is dropped
    write_buf(3'd0, 8'h3C);
    arm_master(1, 8'h96);
    @(negedge clk);
    len_i = 3'd1; ext_clk_i = 1'b0; cs_mode_i = 1'b0;
    start_i = 1'b1; host_we_i = 1'b1; host_addr_i = 3'd0; host_wdata_i = 8'hC3;
    @(negedge clk);
    start_i = 1'b0; host_we_i = 1'b0;
    finish_master(1, "R2");

    // R8 select-gated internal clock: paused while select high
    cs_ni = 1'b1;
    arm_master(2, 8'h21);
    pulse_start(3'd2, 1'b0, 1'b1);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k == 0 || k == 59)
        chk(sck_o && !sck_oe_o && !sdo_oe_o && busy_o, "R8",
            {28'd0, sck_o, sck_oe_o, sdo_oe_o, busy_o}, 32'h9);
    end
    cs_ni = 1'b0;
    #1;
    chk(sdo_oe_o && sck_oe_o && sdo_o == bmem[0][7], "R8",
        {29'd0, sdo_oe_o, sck_oe_o, sdo_o}, {29'd0, 2'b11, bmem[0][7]});
    finish_master(2, "R8");
    cs_ni = 1'b1;

    // R7 external clock, three bytes
    for (int k = 0; k < 3; k++) exp_q.push_back(bmem[3'(k)]);
    done_cnt = 0;
    pulse_start(3'd3, 1'b1, 1'b0);
    chk(!sck_oe_o && busy_o, "R7", {30'd0, sck_oe_o, busy_o}, 32'd1);
    slave_byte(8'h1E, "R7");
    slave_byte(8'hE1, "R7");
    slave_byte(8'h77, "R7");
    chk(!busy_o && done_cnt == 1, "R7", 32'(done_cnt), 32'd1);
    bmem[0] = 8'h1E; bmem[1] = 8'hE1; bmem[2] = 8'h77;
    for (int k = 0; k < 4; k++) rd_chk(3'(k), bmem[3'(k)], "R6");

    // R9 external clock, select-gated, abort mid-byte
    done_cnt = 0;
    pulse_start(3'd2, 1'b1, 1'b1);
    chk(!sdo_oe_o && !sck_oe_o, "R8", {30'd0, sdo_oe_o, sck_oe_o}, 32'd0);
    @(negedge clk);
    cs_ni = 1'b0;
    #1;
    chk(sdo_oe_o && sdo_o == bmem[0][7], "R8", {30'd0, sdo_oe_o, sdo_o}, {30'd1, bmem[0][7]});
    repeat (4) @(negedge clk);
    slave_bits(8'hF0, 3, got);
    chk(got[7:5] == bmem[0][7:5], "R9", 32'(got[7:5]), 32'(bmem[0][7:5]));
    cs_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy_o && !sdo_oe_o, "R9", {30'd0, busy_o, sdo_oe_o}, 32'd2);
    cs_ni = 1'b0;
    repeat (4) @(negedge clk);
    exp_q.push_back(bmem[0]);
    exp_q.push_back(bmem[1]);
    slave_byte(8'h4B, "R9");
    chk(busy_o == 1'b1, "R9", 32'(busy_o), 32'd1);
    slave_byte(8'hB4, "R9");
    chk(!busy_o && done_cnt == 1, "R10", 32'(done_cnt), 32'd1);
    cs_ni = 1'b1;
    bmem[0] = 8'h4B; bmem[1] = 8'hB4;
    for (int k = 0; k < 3; k++) rd_chk(3'(k), bmem[3'(k)], "R9");

    summary();
  end
endmodule